// File: doc/BRIEF.md
# Modulus Up-Counter with Prescaler and External Event Input

The block is a 16-bit up-counter whose advance is gated by a selectable count source: an internal 8-bit reloadable prescaler driven by an upstream tick, or a chosen edge of an external event input. When the counter passes its top value it takes the contents of a modulus latch instead of wrapping to zero, and it raises a sticky interrupt request. Software can later clear that request.

A separate external load input copies the modulus latch into the counter when an enabled edge arrives on it. The rising edge and the falling edge are each enabled by their own bit. In event mode the block acts as a pulse accumulator. Software presets the counter with the two's complement of N, and the request rises on exactly the Nth event. The counter value is driven continuously onto a dedicated output bus for neighbouring timing logic. A small register port gives access to the latch, the control fields and the counter.

Top module: `modcnt_top`

## Requirements
- R1: Each count enable adds one to the counter, and `cnt_bus_o` always shows the current counter value.
- R2: The clock-select field, control bits [1:0], sets the count source: 00 stopped, 01 falling edge of `ext_evt_i`, 10 rising edge of `ext_evt_i`, 11 prescaler output.
- R3: The prescaler counts upstream ticks from the reload value in control bits [15:8] up to 0xFF. At 0xFF it reloads and issues one count enable, so the division ratio is 256 minus the reload value. It also reloads in the cycle after clock-select becomes 11, and a tick in that cycle is ignored.
- R4: A count enable while the counter holds 0xFFFF loads the modulus latch into the counter and sets the flag. `irq_o` shows the flag.
- R5: Writing control with bit 4 set clears the flag, and writing 0 to bit 4 has no effect. An overflow in the same cycle as a clear leaves the flag set. Control reads return the flag in bit 4.
- R6: Control bit 2 enables loading the latch into the counter on a rising edge of `ext_load_i`. Control bit 3 enables the same on a falling edge. An edge whose bit is clear has no effect.
- R7: When an external load and a count enable fall in the same cycle, the counter takes the latch value without adding one.
- R8: A software write to the counter takes effect at once and overrides both a load and a count in the same cycle.
- R9: Both external inputs pass through a two-flip-flop synchronizer. A counter change caused by an input edge appears on the third rising clock edge after the input changes.
- R10: In event mode, with the counter preset to 65536 - N and the flag clear, `irq_o` stays low after N-1 events and rises after the Nth event.
- R11: Register addresses are 0 for the modulus latch, 1 for control and 2 for the counter. Reads return the stored values, and address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address for read and write |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Register read data (combinational) |
| presc_tick_i | input | 1 | Upstream prescaler tick, one cycle per tick |
| ext_load_i | input | 1 | External load input, asynchronous |
| ext_evt_i | input | 1 | External event input, asynchronous |
| cnt_bus_o | output | 16 | Continuous counter value |
| irq_o | output | 1 | Sticky overflow request |

## Verification
The assertions in the counter core assume that the load, count and software-write strobes from the synchronizers and the prescaler are already resolved into single-cycle pulses. They also assume the latch value seen in a cycle is the one loaded at that cycle's edge. The bench keeps external pulses at least four cycles high and four cycles low, so every edge crosses the synchronizer as a clean single pulse. Prescaler ticks are applied only after the cycle in which selection reloads the prescaler. Same-cycle collisions (clear with overflow, load with count, write with tick) are driven on one falling edge, so they meet at a known rising edge.

// File: rtl/modcnt_pkg.sv
package modcnt_pkg;

   typedef enum logic [1:0] {
      CS_STOP     = 2'b00,
      CS_EVT_FALL = 2'b01,
      CS_EVT_RISE = 2'b10,
      CS_PRESC    = 2'b11
   } clk_sel_e;

   localparam logic [1:0] ADDR_LATCH = 2'd0;
   localparam logic [1:0] ADDR_CTRL  = 2'd1;
   localparam logic [1:0] ADDR_COUNT = 2'd2;

   localparam int CTRL_LD_RISE_BIT = 2;
   localparam int CTRL_LD_FALL_BIT = 3;
   localparam int CTRL_FLAG_BIT    = 4;
   localparam int CTRL_RELOAD_LSB  = 8;

endpackage

// File: rtl/modcnt_sync.sv
module modcnt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din_i,
   output logic rise_o,
   output logic fall_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("modcnt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] shift_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         shift_q <= {shift_q[STAGES-2:0], din_i};
         prev_q  <= shift_q[STAGES-1];
      end
   end

   assign rise_o = shift_q[STAGES-1] & ~prev_q;
   assign fall_o = ~shift_q[STAGES-1] & prev_q;

endmodule

// File: rtl/modcnt_presc.sv
module modcnt_presc #(
   parameter int PS_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_i,
   input  logic            sel_i,
   input  logic [PS_W-1:0] reload_i,
   output logic            en_o
);
   localparam logic [PS_W-1:0] PS_MAX = {PS_W{1'b1}};

   logic [PS_W-1:0] cnt_q;
   logic            sel_q;
   logic            fresh_sel;

   assign fresh_sel = sel_i & ~sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sel_q <= 1'b0;
      end else begin
         sel_q <= sel_i;
         if (fresh_sel) begin
            cnt_q <= reload_i;
         end else if (sel_i && tick_i) begin
            cnt_q <= (cnt_q == PS_MAX) ? reload_i : cnt_q + 1'b1;
         end
      end
   end

   assign en_o = sel_i & sel_q & tick_i & (cnt_q == PS_MAX);

   assert_reload_on_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && !sel_q) |=> (cnt_q == $past(reload_i)));

   assert_enable_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      en_o |-> (tick_i && sel_i));

endmodule

// File: rtl/modcnt_core.sv
module modcnt_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_wr_i,
   input  logic [CNT_W-1:0] sw_data_i,
   input  logic             ld_i,
   input  logic             cnt_en_i,
   input  logic [CNT_W-1:0] latch_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             flag_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             flag_q;
   logic             step;
   logic             ovf;

   assign step = cnt_en_i & ~ld_i & ~sw_wr_i;
   assign ovf  = step & (cnt_q == CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (sw_wr_i)      cnt_q <= sw_data_i;
         else if (ld_i)    cnt_q <= latch_i;
         else if (ovf)     cnt_q <= latch_i;
         else if (step)    cnt_q <= cnt_q + 1'b1;

         if (ovf)          flag_q <= 1'b1;
         else if (clr_i)   flag_q <= 1'b0;
      end
   end

   assign cnt_o  = cnt_q;
   assign flag_o = flag_q;

   assert_increment_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en_i && !ld_i && !sw_wr_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

   assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en_i && !ld_i && !sw_wr_i) |=> $stable(cnt_q));

   assert_wrap_to_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en_i && !ld_i && !sw_wr_i && cnt_q == CNT_MAX) |=> (cnt_q == $past(latch_i) && flag_q));

   assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i) |=> flag_q);

   assert_load_beats_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_i && !sw_wr_i) |=> (cnt_q == $past(latch_i)));

   assert_sw_write_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr_i |=> (cnt_q == $past(sw_data_i)));

endmodule

// File: rtl/modcnt_top.sv
module modcnt_top
   import modcnt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PS_W        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr_i,
   input  logic [1:0]       bus_addr_i,
   input  logic [CNT_W-1:0] bus_wdata_i,
   output logic [CNT_W-1:0] bus_rdata_o,
   input  logic             presc_tick_i,
   input  logic             ext_load_i,
   input  logic             ext_evt_i,
   output logic [CNT_W-1:0] cnt_bus_o,
   output logic             irq_o
);
   localparam int N_EXT      = 2;
   localparam int RELOAD_MSB = CTRL_RELOAD_LSB + PS_W - 1;

   generate
      if (CNT_W < CTRL_RELOAD_LSB + PS_W) begin : g_bad_width
         $error("modcnt_top: CNT_W too small for the prescaler reload field");
      end
   endgenerate

   clk_sel_e         csel_q;
   logic             ld_rise_en_q, ld_fall_en_q;
   logic [PS_W-1:0]  reload_q;
   logic [CNT_W-1:0] latch_q;
   logic [CNT_W-1:0] cnt_val;
   logic             flag;

   logic [N_EXT-1:0] ext_in, ext_rise, ext_fall;
   assign ext_in = {ext_load_i, ext_evt_i};

   for (genvar g = 0; g < N_EXT; g++) begin : g_sync
      modcnt_sync #(.STAGES(SYNC_STAGES)) i_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .din_i  (ext_in[g]),
         .rise_o (ext_rise[g]),
         .fall_o (ext_fall[g])
      );
   end

   logic wr_latch, wr_ctrl, wr_count;
   assign wr_latch = bus_wr_i && (bus_addr_i == ADDR_LATCH);
   assign wr_ctrl  = bus_wr_i && (bus_addr_i == ADDR_CTRL);
   assign wr_count = bus_wr_i && (bus_addr_i == ADDR_COUNT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         csel_q       <= CS_STOP;
         ld_rise_en_q <= 1'b0;
         ld_fall_en_q <= 1'b0;
         reload_q     <= '0;
         latch_q      <= '0;
      end else begin
         if (wr_latch) latch_q <= bus_wdata_i;
         if (wr_ctrl) begin
            csel_q       <= clk_sel_e'(bus_wdata_i[1:0]);
            ld_rise_en_q <= bus_wdata_i[CTRL_LD_RISE_BIT];
            ld_fall_en_q <= bus_wdata_i[CTRL_LD_FALL_BIT];
            reload_q     <= bus_wdata_i[RELOAD_MSB:CTRL_RELOAD_LSB];
         end
      end
   end

   logic presc_en;
   modcnt_presc #(.PS_W(PS_W)) i_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (presc_tick_i),
      .sel_i    (csel_q == CS_PRESC),
      .reload_i (reload_q),
      .en_o     (presc_en)
   );

   logic cnt_en, ext_ld;
   always_comb begin
      unique case (csel_q)
         CS_EVT_FALL: cnt_en = ext_fall[0];
         CS_EVT_RISE: cnt_en = ext_rise[0];
         CS_PRESC:    cnt_en = presc_en;
         default:     cnt_en = 1'b0;
      endcase
   end
   assign ext_ld = (ld_rise_en_q & ext_rise[1]) | (ld_fall_en_q & ext_fall[1]);

   modcnt_core #(.CNT_W(CNT_W)) i_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_wr_i   (wr_count),
      .sw_data_i (bus_wdata_i),
      .ld_i      (ext_ld),
      .cnt_en_i  (cnt_en),
      .latch_i   (latch_q),
      .clr_i     (wr_ctrl && bus_wdata_i[CTRL_FLAG_BIT]),
      .cnt_o     (cnt_val),
      .flag_o    (flag)
   );

   always_comb begin
      bus_rdata_o = '0;
      unique case (bus_addr_i)
         ADDR_LATCH: bus_rdata_o = latch_q;
         ADDR_CTRL: begin
            bus_rdata_o[1:0]                        = csel_q;
            bus_rdata_o[CTRL_LD_RISE_BIT]           = ld_rise_en_q;
            bus_rdata_o[CTRL_LD_FALL_BIT]           = ld_fall_en_q;
            bus_rdata_o[CTRL_FLAG_BIT]              = flag;
            bus_rdata_o[RELOAD_MSB:CTRL_RELOAD_LSB] = reload_q;
         end
         ADDR_COUNT: bus_rdata_o = cnt_val;
         default:    bus_rdata_o = '0;
      endcase
   end

   assign cnt_bus_o = cnt_val;
   assign irq_o     = flag;

   assert_stopped_no_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (csel_q == CS_STOP && !ext_ld && !wr_count) |=> $stable(cnt_bus_o));

endmodule

// File: tb/test_modcnt_top.sv
module test_modcnt_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;
   logic        tick = 1'b0;
   logic        ext_ld = 1'b0;
   logic        ext_evt = 1'b0;
   logic [15:0] cnt_bus;
   logic        irq;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   modcnt_top i_modcnt_top (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_wr_i     (bus_wr),
      .bus_addr_i   (bus_addr),
      .bus_wdata_i  (bus_wdata),
      .bus_rdata_o  (bus_rdata),
      .presc_tick_i (tick),
      .ext_load_i   (ext_ld),
      .ext_evt_i    (ext_evt),
      .cnt_bus_o    (cnt_bus),
      .irq_o        (irq)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic evt_pulse();
      @(negedge clk); ext_evt = 1'b1;
      repeat (4) @(negedge clk);
      ext_evt = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic ld_set(input logic v);
      @(negedge clk); ext_ld = v;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 190000);
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk("R1 reset count", cnt_bus, 16'h0000);
      chk("R4 reset irq", {15'h0, irq}, 16'h0);
      rd(2'd1, d); chk("R11 reset ctrl", d, 16'h0000);

      // register map
      wr(2'd0, 16'hBEEF);
      rd(2'd0, d); chk("R11 latch readback", d, 16'hBEEF);
      wr(2'd1, 16'h5A0E);
      rd(2'd1, d); chk("R11 ctrl readback", d, 16'h5A0E);
      rd(2'd3, d); chk("R11 unused address", d, 16'h0000);
      wr(2'd1, 16'h0000);

      // stopped mode ignores events
      wr(2'd2, 16'h0010);
      evt_pulse(); evt_pulse();
      chk("R2 stopped ignores events", cnt_bus, 16'h0010);

      // rising-edge mode with synchronizer latency
      wr(2'd1, 16'h0002);
      @(negedge clk); ext_evt = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R9 no change after two edges", cnt_bus, 16'h0010);
      @(negedge clk);
      chk("R9 change on third edge", cnt_bus, 16'h0011);
      repeat (4) @(negedge clk);
      ext_evt = 1'b0;
      repeat (4) @(negedge clk);
      chk("R2 rising mode ignores falling edge", cnt_bus, 16'h0011);
      for (int i = 0; i < 5; i++) evt_pulse();
      chk("R1 rising mode count", cnt_bus, 16'h0016);

      // falling-edge mode
      wr(2'd1, 16'h0001);
      @(negedge clk); ext_evt = 1'b1;
      repeat (5) @(negedge clk);
      chk("R2 falling mode ignores rising edge", cnt_bus, 16'h0016);
      ext_evt = 1'b0;
      repeat (5) @(negedge clk);
      chk("R2 falling mode counts", cnt_bus, 16'h0017);
      rd(2'd2, d); chk("R11 count readback", d, 16'h0017);

      // overflow reload and flag
      wr(2'd0, 16'h1234);
      wr(2'd1, 16'h0002);
      wr(2'd2, 16'hFFFE);
      evt_pulse();
      chk("R1 reaches top", cnt_bus, 16'hFFFF);
      chk("R4 no flag before overflow", {15'h0, irq}, 16'h0);
      evt_pulse();
      chk("R4 overflow loads latch", cnt_bus, 16'h1234);
      chk("R4 overflow sets irq", {15'h0, irq}, 16'h1);
      rd(2'd1, d); chk("R5 flag readable", d, 16'h0012);
      wr(2'd1, 16'h0002);
      chk("R5 writing 0 keeps flag", {15'h0, irq}, 16'h1);
      wr(2'd1, 16'h0012);
      chk("R5 writing 1 clears flag", {15'h0, irq}, 16'h0);

      // pulse accumulator
      wr(2'd2, 16'hFFFB);
      for (int i = 0; i < 4; i++) evt_pulse();
      chk("R10 irq low after N-1 events", {15'h0, irq}, 16'h0);
      evt_pulse();
      chk("R10 irq high after N events", {15'h0, irq}, 16'h1);
      wr(2'd1, 16'h0010);

      // external load edge enables
      wr(2'd0, 16'hBEEF);
      wr(2'd1, 16'h0004);
      wr(2'd2, 16'h0007);
      ld_set(1'b1);
      chk("R6 rising load", cnt_bus, 16'hBEEF);
      wr(2'd2, 16'h0007);
      ld_set(1'b0);
      chk("R6 falling ignored when disabled", cnt_bus, 16'h0007);
      wr(2'd1, 16'h0008);
      ld_set(1'b1);
      chk("R6 rising ignored when disabled", cnt_bus, 16'h0007);
      ld_set(1'b0);
      chk("R6 falling load", cnt_bus, 16'hBEEF);

      // load and count in the same cycle
      wr(2'd0, 16'h0100);
      wr(2'd1, 16'h0006);
      wr(2'd2, 16'h0010);
      @(negedge clk); ext_ld = 1'b1; ext_evt = 1'b1;
      repeat (5) @(negedge clk);
      chk("R7 load beats count", cnt_bus, 16'h0100);
      ext_ld = 1'b0; ext_evt = 1'b0;
      repeat (5) @(negedge clk);

      // software write beats count; clear collides with overflow
      wr(2'd1, 16'hFF00);
      wr(2'd1, 16'hFF13);
      @(negedge clk);
      wr(2'd2, 16'hFFFF);
      chk("R5 flag clear before collision", {15'h0, irq}, 16'h0);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'hFF13; tick = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; tick = 1'b0;
      chk("R5 overflow wins over clear", {15'h0, irq}, 16'h1);
      chk("R4 prescaler overflow loads latch", cnt_bus, 16'h0100);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 16'h0055; tick = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; tick = 1'b0;
      chk("R8 write beats count", cnt_bus, 16'h0055);

      // prescaler sweep over every reload value
      for (int r = 0; r < 256; r++) begin
         wr(2'd1, {r[7:0], 8'h00});
         wr(2'd2, 16'h0000);
         wr(2'd1, {r[7:0], 8'h03});
         @(negedge clk);
         tick = 1'b1;
         repeat (300) @(negedge clk);
         tick = 1'b0;
         @(negedge clk);
         chk($sformatf("R3 divide reload %0d", r), cnt_bus, 16'(300 / (256 - r)));
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule